// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Aggregator

This block gathers the interrupt events of a serial bus controller and presents them to a host through a small word-addressed register port. Four error events and four protocol events each land in a sticky status register with its own enable mask and a write-one-to-clear register. Each of those two groups then folds into a single summary bit at the second level. The second level also holds two sticky data-request bits: a burst request and a last-burst request.

The second level exposes a raw view, a mask, a masked view, a clear register and a software-set register. The software-set register lets test software raise any second-level bit without a real event. Each of the four second-level bits drives its own interrupt line, and that line equals the masked view. Event inputs are single-cycle pulses from the controller's datapath. A read returns data one cycle after the read strobe.

Register word addresses: 0 error mask, 1 error status, 2 error clear, 3 protocol mask, 4 protocol status, 5 protocol clear, 6 level-2 raw, 7 level-2 mask, 8 level-2 masked, 9 level-2 clear, 10 level-2 set.

Top module: `irq_agg_top`

## Requirements
- R1: After a synchronous reset, every status, mask and force bit is 0, every register reads 0, and all four interrupt outputs are low.
- R2: An error pulse on input bit i (i = 0..3: receive underflow, receive overflow, transmit underflow, transmit overflow) sets bit i of the error status. The bit stays set, whatever its mask, until it is cleared.
- R3: A protocol pulse on input bit j (j = 0..3: arbitration lost, NACK, transmit end, receive turnaround) sets bit j+3 of the protocol status, which occupies bits 3..6.
- R4: A write to a level-1 clear register clears exactly the status bits that are 1 in the written value. A source pulse in the same cycle as a clear of that bit leaves the bit set.
- R5: Level-2 raw bit 4 is the OR of (error status AND error mask). Level-2 raw bit 5 is the OR of (protocol status AND protocol mask).
- R6: Level-2 raw bit 2 (last-burst request) and bit 3 (burst request) set on their pulses, hold until a 1 is written to the same bit of the level-2 clear register, and a pulse in the clearing cycle keeps the bit set.
- R7: Writing 1s to bits 4 and 5 of the level-2 clear register has no effect on those raw bits or their interrupt outputs.
- R8: Level-2 masked status equals raw AND level-2 mask (bits 2..5). The outputs irq_lbreq_o, irq_breq_o, irq_err_o and irq_pro_o equal masked bits 2, 3, 4 and 5.
- R9: Writing a 1 to a bit of the level-2 set register forces that raw bit to 1. A forced bit 2 or 3 behaves as a request. A forced bit 4 or 5 holds until any write to the error or protocol clear register, respectively.
- R10: Mask registers read back only their implemented bits (error 0..3, protocol 3..6, level-2 2..5). The clear and set registers and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt_i | input | 4 | Error event pulses |
| pro_evt_i | input | 4 | Protocol event pulses |
| breq_evt_i | input | 1 | Burst request pulse |
| lbreq_evt_i | input | 1 | Last-burst request pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| irq_lbreq_o | output | 1 | Last-burst request interrupt |
| irq_breq_o | output | 1 | Burst request interrupt |
| irq_err_o | output | 1 | Combined error interrupt |
| irq_pro_o | output | 1 | Combined protocol interrupt |

## Verification
Events are raised in sparse and mixed bit patterns, so a wrong status bit position, such as a protocol event landing at offset 0 instead of 3, shows up in the read-back value. Clears are written with partial patterns, and with an all-zero value, to tell "clear the written ones" apart from "clear all". Collisions of an event pulse with its own clear separate set-wins priority from clear-wins priority. The mask is toggled at both levels, which shows whether the summary bits and interrupt lines follow status AND mask rather than the bare status. Writes of summary bits to the level-2 clear register, and forced bits released through a level-1 clear, check that the two levels stay separate.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_ERR_MASK  = 4'd0;
  localparam logic [AW-1:0] A_ERR_STAT  = 4'd1;
  localparam logic [AW-1:0] A_ERR_CLR   = 4'd2;
  localparam logic [AW-1:0] A_PRO_MASK  = 4'd3;
  localparam logic [AW-1:0] A_PRO_STAT  = 4'd4;
  localparam logic [AW-1:0] A_PRO_CLR   = 4'd5;
  localparam logic [AW-1:0] A_L2_RAW    = 4'd6;
  localparam logic [AW-1:0] A_L2_MASK   = 4'd7;
  localparam logic [AW-1:0] A_L2_MASKED = 4'd8;
  localparam logic [AW-1:0] A_L2_CLR    = 4'd9;
  localparam logic [AW-1:0] A_L2_SET    = 4'd10;

  // bit offsets decoded by the host
  localparam int ERR_LSB = 0;
  localparam int PRO_LSB = 3;
  localparam int L2_LSB  = 2;
  localparam int L2_LB   = 2;
  localparam int L2_BR   = 3;
  localparam int L2_ER   = 4;
  localparam int L2_PR   = 5;
  localparam int L2_N    = 4;
endpackage

// File: rtl/irq_l1_group.sv
module irq_l1_group #(
  parameter int DW   = 8,
  parameter int NSRC = 4,
  parameter int LSB  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            mask_we_i,
  input  logic            clr_we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   mask_o,
  output logic [DW-1:0]   stat_o,
  output logic            any_o
);
  localparam int PAD = DW - NSRC;

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] field;
  logic [NSRC-1:0] clr_bits;

  assign field    = wdata_i[LSB +: NSRC];
  assign clr_bits = clr_we_i ? field : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= field;
      // new events win over a clear of the same bit
      stat_q <= (stat_q & ~clr_bits) | src_i;
    end
  end

  assign mask_o = {{PAD{1'b0}}, mask_q} << LSB;
  assign stat_o = {{PAD{1'b0}}, stat_q} << LSB;
  assign any_o  = |(stat_q & mask_q);

  // R2/R3: a status bit without a clear write stays set
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_we_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R4: a pulse always leaves its bit set, even against a clear
  assert_setwins_R4: assert property (@(posedge clk) disable iff (rst)
    (src_i != '0) |=> ((stat_q & $past(src_i)) == $past(src_i)));
endmodule

// File: rtl/irq_l2_bank.sv
module irq_l2_bank
  import irq_agg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_i,
  input  logic              br_i,
  input  logic              err_any_i,
  input  logic              pro_any_i,
  input  logic              err_l1clr_i,
  input  logic              pro_l1clr_i,
  input  logic              mask_we_i,
  input  logic              clr_we_i,
  input  logic              set_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     raw_o,
  output logic [DW-1:0]     mask_o,
  output logic [DW-1:0]     masked_o,
  output logic [L2_N-1:0]   irq_o
);
  localparam int PAD = DW - L2_N - L2_LSB;

  logic            lb_q, br_q, frc_err_q, frc_pro_q;
  logic [L2_N-1:0] mask_q;
  logic [L2_N-1:0] raw4;
  logic            clr_lb, clr_br, set_lb, set_br, set_er, set_pr;

  assign clr_lb = clr_we_i & wdata_i[L2_LB];
  assign clr_br = clr_we_i & wdata_i[L2_BR];
  assign set_lb = set_we_i & wdata_i[L2_LB];
  assign set_br = set_we_i & wdata_i[L2_BR];
  assign set_er = set_we_i & wdata_i[L2_ER];
  assign set_pr = set_we_i & wdata_i[L2_PR];

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_q      <= 1'b0;
      br_q      <= 1'b0;
      frc_err_q <= 1'b0;
      frc_pro_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      lb_q <= (lb_q & ~clr_lb) | lb_i | set_lb;
      br_q <= (br_q & ~clr_br) | br_i | set_br;
      if (set_er)           frc_err_q <= 1'b1;
      else if (err_l1clr_i) frc_err_q <= 1'b0;
      if (set_pr)           frc_pro_q <= 1'b1;
      else if (pro_l1clr_i) frc_pro_q <= 1'b0;
      if (mask_we_i) mask_q <= wdata_i[L2_LSB +: L2_N];
    end
  end

  assign raw4     = {pro_any_i | frc_pro_q, err_any_i | frc_err_q, br_q, lb_q};
  assign raw_o    = {{PAD{1'b0}}, raw4, {L2_LSB{1'b0}}};
  assign mask_o   = {{PAD{1'b0}}, mask_q, {L2_LSB{1'b0}}};
  assign masked_o = {{PAD{1'b0}}, raw4 & mask_q, {L2_LSB{1'b0}}};
  assign irq_o    = raw4 & mask_q;

  // R6: a clear write with no pulse or set drops the request bit
  assert_lb_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_lb && !lb_i && !set_lb) |=> !lb_q);

  // R6: a pulse keeps the burst request set in the following cycle
  assert_br_set_R6: assert property (@(posedge clk) disable iff (rst)
    br_i |=> br_q);

  // R9: a software set of the summary bit raises its interrupt raw view
  assert_force_R9: assert property (@(posedge clk) disable iff (rst)
    set_er |=> raw4[L2_ER - L2_LSB]);
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] err_evt_i,
  input  logic [NSRC-1:0] pro_evt_i,
  input  logic            breq_evt_i,
  input  logic            lbreq_evt_i,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_lbreq_o,
  output logic            irq_breq_o,
  output logic            irq_err_o,
  output logic            irq_pro_o
);
  localparam int NGRP = 2;

  logic [NGRP-1:0][NSRC-1:0] l1_src;
  logic [NGRP-1:0][DW-1:0]   l1_mask, l1_stat;
  logic [NGRP-1:0]           l1_any, l1_mwe, l1_cwe;
  logic [DW-1:0]             l2_raw, l2_mask, l2_masked;
  logic [L2_N-1:0]           irq_vec;

  assign l1_src[0] = err_evt_i;
  assign l1_src[1] = pro_evt_i;
  assign l1_mwe[0] = reg_we_i && (reg_addr_i == A_ERR_MASK);
  assign l1_cwe[0] = reg_we_i && (reg_addr_i == A_ERR_CLR);
  assign l1_mwe[1] = reg_we_i && (reg_addr_i == A_PRO_MASK);
  assign l1_cwe[1] = reg_we_i && (reg_addr_i == A_PRO_CLR);

  for (genvar g = 0; g < NGRP; g++) begin : g_l1
    localparam int GLSB = (g == 0) ? ERR_LSB : PRO_LSB;
    irq_l1_group #(.DW(DW), .NSRC(NSRC), .LSB(GLSB)) u_grp (
      .clk       (clk),
      .rst       (rst),
      .src_i     (l1_src[g]),
      .mask_we_i (l1_mwe[g]),
      .clr_we_i  (l1_cwe[g]),
      .wdata_i   (reg_wdata_i),
      .mask_o    (l1_mask[g]),
      .stat_o    (l1_stat[g]),
      .any_o     (l1_any[g])
    );
  end

  irq_l2_bank #(.DW(DW)) u_l2 (
    .clk         (clk),
    .rst         (rst),
    .lb_i        (lbreq_evt_i),
    .br_i        (breq_evt_i),
    .err_any_i   (l1_any[0]),
    .pro_any_i   (l1_any[1]),
    .err_l1clr_i (l1_cwe[0]),
    .pro_l1clr_i (l1_cwe[1]),
    .mask_we_i   (reg_we_i && (reg_addr_i == A_L2_MASK)),
    .clr_we_i    (reg_we_i && (reg_addr_i == A_L2_CLR)),
    .set_we_i    (reg_we_i && (reg_addr_i == A_L2_SET)),
    .wdata_i     (reg_wdata_i),
    .raw_o       (l2_raw),
    .mask_o      (l2_mask),
    .masked_o    (l2_masked),
    .irq_o       (irq_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else if (reg_re_i) begin
      case (reg_addr_i)
        A_ERR_MASK:  reg_rdata_o <= l1_mask[0];
        A_ERR_STAT:  reg_rdata_o <= l1_stat[0];
        A_PRO_MASK:  reg_rdata_o <= l1_mask[1];
        A_PRO_STAT:  reg_rdata_o <= l1_stat[1];
        A_L2_RAW:    reg_rdata_o <= l2_raw;
        A_L2_MASK:   reg_rdata_o <= l2_mask;
        A_L2_MASKED: reg_rdata_o <= l2_masked;
        default:     reg_rdata_o <= '0;
      endcase
    end
  end

  assign irq_lbreq_o = irq_vec[L2_LB - L2_LSB];
  assign irq_breq_o  = irq_vec[L2_BR - L2_LSB];
  assign irq_err_o   = irq_vec[L2_ER - L2_LSB];
  assign irq_pro_o   = irq_vec[L2_PR - L2_LSB];

  // R1: the cycle after reset all interrupt lines are low
  assert_quiet_R1: assert property (@(posedge clk)
    rst |=> !(irq_lbreq_o || irq_breq_o || irq_err_o || irq_pro_o));

  // R10: a read of a clear register returns 0
  assert_rdclr_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_re_i && (reg_addr_i == A_ERR_CLR || reg_addr_i == A_L2_SET))
    |=> (reg_rdata_o == '0));
endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] err_evt = '0, pro_evt = '0;
  logic       breq = 1'b0, lbreq = 1'b0;
  logic       we = 1'b0, re = 1'b0, re_d = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_lb, irq_br, irq_er, irq_pr;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  irq_agg_top dut (
    .clk(clk), .rst(rst), .err_evt_i(err_evt), .pro_evt_i(pro_evt),
    .breq_evt_i(breq), .lbreq_evt_i(lbreq), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_lbreq_o(irq_lb), .irq_breq_o(irq_br), .irq_err_o(irq_er),
    .irq_pro_o(irq_pr)
  );

  always @(posedge clk) re_d <= re;

  // monitor: compare read data with the scoreboard queue
  always @(negedge clk) begin
    if (re_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk); re = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); re = 1'b0;
  endtask

  // event pulses, optionally together with a register write
  task automatic ev(input logic [3:0] ee, input logic [3:0] pe, input logic b,
                    input logic lb, input logic w, input logic [3:0] a,
                    input logic [7:0] d);
    @(negedge clk);
    err_evt = ee; pro_evt = pe; breq = b; lbreq = lb;
    we = w; addr = a; wdata = d;
    @(negedge clk);
    err_evt = '0; pro_evt = '0; breq = 1'b0; lbreq = 1'b0; we = 1'b0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    total++;
    if ({irq_pr, irq_er, irq_br, irq_lb} !== e) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", t, {irq_pr, irq_er, irq_br, irq_lb}, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(4'b0000, "R1 irq after reset");
    for (int a = 0; a < 11; a++) rd(a[3:0], 8'h00, "R1 register after reset");

    // R2 / R3 bit placement, mask zero
    ev(4'b0101, 4'b1010, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    rd(4'd1, 8'h05, "R2 error status");
    rd(4'd4, 8'h50, "R3 protocol status");
    rd(4'd6, 8'h00, "R5 raw with level-1 masks off");

    // R5 / R8
    wr(4'd0, 8'h04);
    rd(4'd6, 8'h10, "R5 error summary raw");
    chk_irq(4'b0000, "R8 level-2 mask off");
    wr(4'd7, 8'h3C);
    chk_irq(4'b0100, "R8 irq_err follows masked");
    rd(4'd8, 8'h10, "R8 masked view");

    // R4 partial clear
    wr(4'd2, 8'h04);
    rd(4'd1, 8'h01, "R4 clear written ones only");
    rd(4'd6, 8'h00, "R5 summary drops after clear");
    chk_irq(4'b0000, "R4 irq_err low after clear");

    // R4 set wins
    ev(4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 4'd2, 8'h01);
    rd(4'd1, 8'h01, "R4 pulse beats clear");

    // R7 summary bits ignore level-2 clear
    wr(4'd0, 8'h01);
    wr(4'd9, 8'h30);
    rd(4'd6, 8'h10, "R7 summary survives level-2 clear");
    chk_irq(4'b0100, "R7 irq_err stays");

    // R6 burst requests
    ev(4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk_irq(4'b0110, "R6 burst irq");
    ev(4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    rd(4'd6, 8'h1C, "R6 both requests set");
    wr(4'd9, 8'h08);
    rd(4'd6, 8'h14, "R6 burst cleared");
    ev(4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 4'd9, 8'h04);
    rd(4'd6, 8'h14, "R6 pulse beats level-2 clear");

    // R8 mask selection
    wr(4'd7, 8'h04);
    rd(4'd8, 8'h04, "R8 masked equals raw and mask");
    rd(4'd7, 8'h04, "R10 level-2 mask readback");
    chk_irq(4'b0001, "R8 only last-burst line");

    // R9 software set
    wr(4'd10, 8'h20);
    rd(4'd6, 8'h34, "R9 forced protocol summary");
    wr(4'd10, 8'h08);
    rd(4'd6, 8'h3C, "R9 forced burst");
    wr(4'd5, 8'h00);
    rd(4'd6, 8'h1C, "R9 force released by protocol clear write");
    rd(4'd4, 8'h50, "R4 zero clear keeps status");

    // R10 implemented bits
    wr(4'd0, 8'hFF);
    rd(4'd0, 8'h0F, "R10 error mask bits");
    wr(4'd3, 8'hFF);
    rd(4'd3, 8'h78, "R10 protocol mask bits");
    rd(4'd2, 8'h00, "R10 clear register reads 0");
    rd(4'd6, 8'h3C, "R5 both summaries with full masks");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule